// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the interlock and forwarding control for a five-stage in-order integer pipeline. Its stages are fetch, decode with register read, ALU, data memory and register write-back. Each cycle it receives a description of three instructions: the one in decode, the one in the ALU stage and the one in the memory stage. It returns the operand-bypass selects, a stall that freezes fetch and decode, a bubble request for the ALU stage, and a fetch hold with a decode bubble for the case where one memory port serves both instructions and data.

The register file writes in the first half of a cycle and reads in the second half. A producer three instructions ahead is therefore already visible through the register file. The selects are worked out while the consumer sits in decode and are registered. The ALU operand selects apply while that instruction occupies the ALU stage. The store-data select applies one cycle later, while the store occupies the memory stage.

Two compile-time switches set the variant. `BYPASS` set to 0 removes every bypass path and leaves pure interlocking. `UNIFIED` set to 1 models a single shared instruction/data memory port.

Top module: `hz_ctl`

## Requirements
- R1: A decode source matches an older instruction only when all of the following hold: the older instruction is valid, its write enable is high, its destination is non-zero and equals the source, and the source's use flag is high. A bubble is valid=0 with write enable 0 and never causes a forward or a stall.
- R2: Class codes are 0 ALU, 1 load, 2 store and 3 branch. Source 1 is ALU operand A or the memory address; source 2 is ALU operand B or the store data. Select codes are 0 for register file, 1 for the ALU/memory latch and 2 for the memory/write-back latch. After reset all selects are 0.
- R3: A producer three or more instructions older than its consumer causes no stall and no forward.
- R4: With `BYPASS`=0 every select stays 0. An adjacent consumer stalls 2 cycles and a consumer two behind stalls 1 cycle, whatever the producer class.
- R5: With `BYPASS`=1 a non-load producer causes 0 stall cycles. The consumer's ALU-stage select is 1 for an adjacent producer and 2 for a producer two ahead.
- R6: With `BYPASS`=1 a load whose result is used as an ALU operand, an address or a branch operand by the next instruction causes exactly 1 stall cycle, after which the select is 2.
- R7: With `BYPASS`=1 a load followed by a store that uses the loaded value only as its data causes 0 stalls. `fwd_sd` is 1 while that store is in the memory stage.
- R8: While `stall` is high, `bubble_ex` and `fetch_hold` are high and `bubble_id` is low. The ALU-stage selects in the following cycle are 0.
- R9: When several older instructions write the same register, the youngest one supplies the forward. An adjacent ALU producer shadows an older load, so no stall occurs.
- R10: With `UNIFIED`=1, a load or store in the memory stage raises `fetch_hold`, and also raises `bubble_id` when no stall is active. With `UNIFIED`=0, `bubble_id` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid | input | 1 | Decode-stage instruction valid |
| id_cls | input | 2 | Decode-stage class |
| id_rs1 | input | REG_W | Decode source 1 |
| id_rs2 | input | REG_W | Decode source 2 |
| id_use1 | input | 1 | Source 1 is read |
| id_use2 | input | 1 | Source 2 is read |
| ex_valid | input | 1 | ALU-stage instruction valid |
| ex_we | input | 1 | ALU-stage write enable |
| ex_cls | input | 2 | ALU-stage class |
| ex_rd | input | REG_W | ALU-stage destination |
| mem_valid | input | 1 | Memory-stage instruction valid |
| mem_we | input | 1 | Memory-stage write enable |
| mem_cls | input | 2 | Memory-stage class |
| mem_rd | input | REG_W | Memory-stage destination |
| stall | output | 1 | Freeze fetch and decode |
| bubble_ex | output | 1 | Insert bubble into ALU stage |
| fetch_hold | output | 1 | Do not fetch this cycle |
| bubble_id | output | 1 | Insert bubble into decode stage |
| fwd_a | output | 2 | Operand A select for instruction in ALU stage |
| fwd_b | output | 2 | Operand B select for instruction in ALU stage |
| fwd_sd | output | 1 | Store data from write-back latch in memory stage |

## Verification
The hardest situations to reach are those where the controller's own stall reshapes the stage occupancy it later sees. Examples are a load feeding a store address, which must show select 2 only after the one-cycle freeze, and two older writers of one register where the older one is a load. The bench therefore drives the block from a behavioural pipeline that obeys `stall` and `fetch_hold` exactly as the real datapath would. It feeds directed instruction pairs and triples, and a mixed program, into two instances: one with bypassing and one with interlock only plus a shared memory port. It then compares stall totals and every cycle's selects with a reference that locates the youngest older writer by program order.

// File: rtl/hz_pkg.sv
package hz_pkg;
   typedef enum logic [1:0] {
      CL_ALU    = 2'd0,
      CL_LOAD   = 2'd1,
      CL_STORE  = 2'd2,
      CL_BRANCH = 2'd3
   } cls_e;

   localparam logic [1:0] FWD_RF  = 2'd0;
   localparam logic [1:0] FWD_EXM = 2'd1;
   localparam logic [1:0] FWD_MWB = 2'd2;

   localparam int N_SRC = 2;
endpackage

// File: rtl/hz_src_fwd.sv
module hz_src_fwd
   import hz_pkg::*;
#(
   parameter int REG_W  = 5,
   parameter int BYPASS = 1
) (
   input  logic             id_valid,
   input  logic [REG_W-1:0] src,
   input  logic             use_i,
   input  logic             ex_valid,
   input  logic             ex_we,
   input  logic             ex_load,
   input  logic [REG_W-1:0] ex_rd,
   input  logic             mem_valid,
   input  logic             mem_we,
   input  logic [REG_W-1:0] mem_rd,
   output logic             hit_ex,
   output logic             hit_mem,
   output logic [1:0]       sel
);
   localparam bit FWD_ON = (BYPASS != 0);

   logic src_live;
   assign src_live = id_valid && use_i && (src != '0);
   assign hit_ex   = src_live && ex_valid && ex_we && (ex_rd == src);
   assign hit_mem  = src_live && mem_valid && mem_we && (mem_rd == src);

   // nearest stage is tested first, so the youngest writer wins
   always_comb begin
      sel = FWD_RF;
      if (FWD_ON) begin
         if (hit_ex)
            sel = ex_load ? FWD_RF : FWD_EXM;
         else if (hit_mem)
            sel = FWD_MWB;
      end
   end
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
   import hz_pkg::*;
#(
   parameter int BYPASS  = 1,
   parameter int UNIFIED = 0
) (
   input  logic [N_SRC-1:0] hit_ex,
   input  logic [N_SRC-1:0] hit_mem,
   input  logic             ex_load,
   input  logic             id_store,
   input  logic             mem_valid,
   input  logic [1:0]       mem_cls,
   output logic             stall,
   output logic             conflict
);
   localparam bit FWD_ON = (BYPASS != 0);
   localparam bit ONE_PORT = (UNIFIED != 0);

   logic st_fwd, st_lock, mem_access;

   // with forwarding only a load one ahead blocks; store data is exempt
   assign st_fwd  = ex_load && (hit_ex[0] || (hit_ex[1] && !id_store));
   assign st_lock = (|hit_ex) || (|hit_mem);
   assign stall   = FWD_ON ? st_fwd : st_lock;

   assign mem_access = mem_valid &&
                       ((mem_cls == CL_LOAD) || (mem_cls == CL_STORE));
   assign conflict   = ONE_PORT && mem_access;
endmodule

// File: rtl/hz_ctl.sv
module hz_ctl
   import hz_pkg::*;
#(
   parameter int REG_W   = 5,
   parameter int BYPASS  = 1,
   parameter int UNIFIED = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             id_valid,
   input  logic [1:0]       id_cls,
   input  logic [REG_W-1:0] id_rs1,
   input  logic [REG_W-1:0] id_rs2,
   input  logic             id_use1,
   input  logic             id_use2,
   input  logic             ex_valid,
   input  logic             ex_we,
   input  logic [1:0]       ex_cls,
   input  logic [REG_W-1:0] ex_rd,
   input  logic             mem_valid,
   input  logic             mem_we,
   input  logic [1:0]       mem_cls,
   input  logic [REG_W-1:0] mem_rd,
   output logic             stall,
   output logic             bubble_ex,
   output logic             fetch_hold,
   output logic             bubble_id,
   output logic [1:0]       fwd_a,
   output logic [1:0]       fwd_b,
   output logic             fwd_sd
);
   localparam bit FWD_ON = (BYPASS != 0);

   if (REG_W < 2 || REG_W > 8) begin : g_bad_regw
      $error("hz_ctl: REG_W must lie in 2..8");
   end
   if (BYPASS < 0 || BYPASS > 1) begin : g_bad_byp
      $error("hz_ctl: BYPASS must be 0 or 1");
   end
   if (UNIFIED < 0 || UNIFIED > 1) begin : g_bad_uni
      $error("hz_ctl: UNIFIED must be 0 or 1");
   end

   logic [REG_W-1:0] src_v [N_SRC];
   logic [N_SRC-1:0] use_v;
   logic [N_SRC-1:0] hit_ex_v, hit_mem_v;
   logic [1:0]       sel_v [N_SRC];
   logic             ex_load, id_store, conflict, sd_d;
   logic [1:0]       fa_q, fb_q;
   logic             sd_ex_q, sd_mem_q;

   assign src_v[0] = id_rs1;
   assign src_v[1] = id_rs2;
   assign use_v    = {id_use2, id_use1};
   assign ex_load  = (ex_cls == CL_LOAD);
   assign id_store = (id_cls == CL_STORE);

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      hz_src_fwd #(.REG_W(REG_W), .BYPASS(BYPASS)) u_fwd (
         .id_valid (id_valid),
         .src      (src_v[i]),
         .use_i    (use_v[i]),
         .ex_valid (ex_valid),
         .ex_we    (ex_we),
         .ex_load  (ex_load),
         .ex_rd    (ex_rd),
         .mem_valid(mem_valid),
         .mem_we   (mem_we),
         .mem_rd   (mem_rd),
         .hit_ex   (hit_ex_v[i]),
         .hit_mem  (hit_mem_v[i]),
         .sel      (sel_v[i])
      );
   end

   hz_interlock #(.BYPASS(BYPASS), .UNIFIED(UNIFIED)) u_lock (
      .hit_ex   (hit_ex_v),
      .hit_mem  (hit_mem_v),
      .ex_load  (ex_load),
      .id_store (id_store),
      .mem_valid(mem_valid),
      .mem_cls  (mem_cls),
      .stall    (stall),
      .conflict (conflict)
   );

   // loaded value reaches a store's data input from the write-back latch
   assign sd_d = FWD_ON && id_store && hit_ex_v[1] && ex_load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fa_q     <= FWD_RF;
         fb_q     <= FWD_RF;
         sd_ex_q  <= 1'b0;
         sd_mem_q <= 1'b0;
      end else begin
         if (stall || !id_valid) begin
            fa_q    <= FWD_RF;
            fb_q    <= FWD_RF;
            sd_ex_q <= 1'b0;
         end else begin
            fa_q    <= sel_v[0];
            fb_q    <= sel_v[1];
            sd_ex_q <= sd_d;
         end
         sd_mem_q <= sd_ex_q;
      end
   end

   assign bubble_ex  = stall;
   assign fetch_hold = stall || conflict;
   assign bubble_id  = conflict && !stall;
   assign fwd_a      = fa_q;
   assign fwd_b      = fb_q;
   assign fwd_sd     = sd_mem_q;
endmodule

// File: rtl/hz_ctl_chk.sv
module hz_ctl_chk
   import hz_pkg::*;
#(
   parameter int REG_W   = 5,
   parameter int BYPASS  = 1,
   parameter int UNIFIED = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             id_valid,
   input logic [REG_W-1:0] id_rs1,
   input logic [REG_W-1:0] id_rs2,
   input logic             id_use1,
   input logic             id_use2,
   input logic             ex_valid,
   input logic [1:0]       ex_cls,
   input logic             mem_valid,
   input logic             mem_we,
   input logic [1:0]       mem_cls,
   input logic             stall,
   input logic             bubble_ex,
   input logic             fetch_hold,
   input logic             bubble_id,
   input logic [1:0]       fwd_a,
   input logic [1:0]       fwd_b,
   input logic             fwd_sd
);
   logic mem_op;
   assign mem_op = mem_valid && ((mem_cls == CL_LOAD) || (mem_cls == CL_STORE));

   p_use_gate_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_a != FWD_RF) |-> $past(id_valid && id_use1 && id_rs1 != '0));

   p_use_gate_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_b != FWD_RF) |-> $past(id_valid && id_use2 && id_rs2 != '0));

   p_interlock_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (BYPASS == 0) |-> (fwd_a == FWD_RF && fwd_b == FWD_RF && !fwd_sd));

   p_load_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (BYPASS != 0 && stall) |-> (ex_valid && ex_cls == CL_LOAD));

   p_sd_from_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_sd |-> $past(mem_valid && mem_we && mem_cls == CL_LOAD));

   p_stall_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (bubble_ex && fetch_hold && !bubble_id));

   p_after_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stall) |-> (fwd_a == FWD_RF && fwd_b == FWD_RF));

   p_port_share_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_op && !stall) |-> (bubble_id == (UNIFIED != 0) && fetch_hold == (UNIFIED != 0)));
endmodule

bind hz_ctl hz_ctl_chk #(.REG_W(REG_W), .BYPASS(BYPASS), .UNIFIED(UNIFIED)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .id_valid  (id_valid),
   .id_rs1    (id_rs1),
   .id_rs2    (id_rs2),
   .id_use1   (id_use1),
   .id_use2   (id_use2),
   .ex_valid  (ex_valid),
   .ex_cls    (ex_cls),
   .mem_valid (mem_valid),
   .mem_we    (mem_we),
   .mem_cls   (mem_cls),
   .stall     (stall),
   .bubble_ex (bubble_ex),
   .fetch_hold(fetch_hold),
   .bubble_id (bubble_id),
   .fwd_a     (fwd_a),
   .fwd_b     (fwd_b),
   .fwd_sd    (fwd_sd)
);

// File: tb/sim_hz_ctl.sv
`timescale 1ns/1ps
module sim_hz_ctl;
   localparam int RW   = 5;
   localparam int MAXP = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   // lane 0: bypass, split memories; lane 1: interlock only, shared port
   logic          d_idv [2];
   logic [1:0]    d_idc [2];
   logic [RW-1:0] d_rs1 [2];
   logic [RW-1:0] d_rs2 [2];
   logic          d_u1  [2];
   logic          d_u2  [2];
   logic          d_exv [2];
   logic          d_exwe[2];
   logic [1:0]    d_exc [2];
   logic [RW-1:0] d_exrd[2];
   logic          d_mv  [2];
   logic          d_mwe [2];
   logic [1:0]    d_mc  [2];
   logic [RW-1:0] d_mrd [2];
   logic          o_st  [2];
   logic          o_bex [2];
   logic          o_fh  [2];
   logic          o_bid [2];
   logic [1:0]    o_fa  [2];
   logic [1:0]    o_fb  [2];
   logic          o_sd  [2];

   hz_ctl #(.REG_W(RW), .BYPASS(1), .UNIFIED(0)) u0 (
      .clk(clk), .rst_n(rst_n),
      .id_valid(d_idv[0]), .id_cls(d_idc[0]), .id_rs1(d_rs1[0]), .id_rs2(d_rs2[0]),
      .id_use1(d_u1[0]), .id_use2(d_u2[0]),
      .ex_valid(d_exv[0]), .ex_we(d_exwe[0]), .ex_cls(d_exc[0]), .ex_rd(d_exrd[0]),
      .mem_valid(d_mv[0]), .mem_we(d_mwe[0]), .mem_cls(d_mc[0]), .mem_rd(d_mrd[0]),
      .stall(o_st[0]), .bubble_ex(o_bex[0]), .fetch_hold(o_fh[0]), .bubble_id(o_bid[0]),
      .fwd_a(o_fa[0]), .fwd_b(o_fb[0]), .fwd_sd(o_sd[0]));

   hz_ctl #(.REG_W(RW), .BYPASS(0), .UNIFIED(1)) u1 (
      .clk(clk), .rst_n(rst_n),
      .id_valid(d_idv[1]), .id_cls(d_idc[1]), .id_rs1(d_rs1[1]), .id_rs2(d_rs2[1]),
      .id_use1(d_u1[1]), .id_use2(d_u2[1]),
      .ex_valid(d_exv[1]), .ex_we(d_exwe[1]), .ex_cls(d_exc[1]), .ex_rd(d_exrd[1]),
      .mem_valid(d_mv[1]), .mem_we(d_mwe[1]), .mem_cls(d_mc[1]), .mem_rd(d_mrd[1]),
      .stall(o_st[1]), .bubble_ex(o_bex[1]), .fetch_hold(o_fh[1]), .bubble_id(o_bid[1]),
      .fwd_a(o_fa[1]), .fwd_b(o_fb[1]), .fwd_sd(o_sd[1]));

   // program under test
   int p_cls [MAXP];
   int p_rd  [MAXP];
   int p_rs1 [MAXP];
   int p_rs2 [MAXP];
   bit p_we  [MAXP];
   bit p_u1  [MAXP];
   bit p_u2  [MAXP];
   int plen;

   // behavioural pipeline per lane: program index or -1 for a bubble
   int s_id [2];
   int s_ex [2];
   int s_mem[2];
   int s_wb [2];
   int s_fi [2];
   int stalls[2];
   int bids  [2];

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   task automatic clr();
      plen = 0;
   endtask

   task automatic add(input int cls, input int rd, input int rs1, input int rs2,
                      input bit u1, input bit u2, input bit we);
      p_cls[plen] = cls; p_rd[plen] = rd; p_rs1[plen] = rs1; p_rs2[plen] = rs2;
      p_u1[plen] = u1; p_u2[plen] = u2; p_we[plen] = we;
      plen++;
   endtask

   task automatic i_alu(input int rd, input int a, input int b); add(0, rd, a, b, 1, 1, 1); endtask
   task automatic i_ld (input int rd, input int base);           add(1, rd, base, 0, 1, 0, 1); endtask
   task automatic i_st (input int base, input int data);         add(2, 0, base, data, 1, 1, 0); endtask
   task automatic i_br (input int a, input int b);               add(3, 0, a, b, 1, 1, 0); endtask
   task automatic i_nop();                                       add(0, 0, 0, 0, 0, 0, 0); endtask

   function automatic int writer(input int k, input int src);
      if (src == 0) return -1;
      for (int j = k - 1; j >= 0; j--)
         if (p_we[j] && p_rd[j] == src) return j;
      return -1;
   endfunction

   function automatic int ref_op(input int l, input int which);
      int k, src, j;
      k = s_ex[l];
      if (k < 0 || l != 0) return 0;
      if (which == 0 && !p_u1[k]) return 0;
      if (which == 1 && !p_u2[k]) return 0;
      src = (which == 0) ? p_rs1[k] : p_rs2[k];
      j = writer(k, src);
      if (j < 0) return 0;
      if (j == s_mem[l]) return (p_cls[j] == 1) ? 0 : 1;
      if (j == s_wb[l]) return 2;
      return 0;
   endfunction

   function automatic int ref_sd(input int l);
      int k, j;
      k = s_mem[l];
      if (k < 0 || l != 0 || p_cls[k] != 2 || !p_u2[k]) return 0;
      j = writer(k, p_rs2[k]);
      return (j >= 0 && j == s_wb[l] && p_cls[j] == 1) ? 1 : 0;
   endfunction

   task automatic drive(input int l);
      int k, e, m;
      k = s_id[l]; e = s_ex[l]; m = s_mem[l];
      d_idv[l] = (k >= 0);
      d_idc[l] = (k >= 0) ? 2'(p_cls[k]) : 2'd0;
      d_rs1[l] = (k >= 0) ? RW'(p_rs1[k]) : '0;
      d_rs2[l] = (k >= 0) ? RW'(p_rs2[k]) : '0;
      d_u1[l]  = (k >= 0) ? p_u1[k] : 1'b0;
      d_u2[l]  = (k >= 0) ? p_u2[k] : 1'b0;
      d_exv[l] = (e >= 0);
      d_exwe[l]= (e >= 0) ? p_we[e] : 1'b0;
      d_exc[l] = (e >= 0) ? 2'(p_cls[e]) : 2'd0;
      d_exrd[l]= (e >= 0) ? RW'(p_rd[e]) : '0;
      d_mv[l]  = (m >= 0);
      d_mwe[l] = (m >= 0) ? p_we[m] : 1'b0;
      d_mc[l]  = (m >= 0) ? 2'(p_cls[m]) : 2'd0;
      d_mrd[l] = (m >= 0) ? RW'(p_rd[m]) : '0;
   endtask

   function automatic bit lane_busy(input int l);
      return (s_id[l] >= 0 || s_ex[l] >= 0 || s_mem[l] >= 0 || s_wb[l] >= 0 || s_fi[l] < plen);
   endfunction

   task automatic step();
      @(negedge clk);
      for (int l = 0; l < 2; l++) drive(l);
      #1;
      for (int l = 0; l < 2; l++) begin
         bit memop;
         int expb;
         chk("R5 R6 R9", "fwd_a", int'(o_fa[l]), ref_op(l, 0));
         chk("R5 R6 R9", "fwd_b", int'(o_fb[l]), ref_op(l, 1));
         chk("R7", "fwd_sd", int'(o_sd[l]), ref_sd(l));
         chk("R8", "bubble_ex", int'(o_bex[l]), int'(o_st[l]));
         memop = (s_mem[l] >= 0) && (p_cls[s_mem[l]] == 1 || p_cls[s_mem[l]] == 2);
         expb  = (l == 1 && memop && !o_st[l]) ? 1 : 0;
         chk("R10", "bubble_id", int'(o_bid[l]), expb);
         chk("R8 R10", "fetch_hold", int'(o_fh[l]), (o_st[l] || expb) ? 1 : 0);
      end
      for (int l = 0; l < 2; l++) begin
         s_wb[l] = s_mem[l];
         s_mem[l] = s_ex[l];
         if (o_st[l]) begin
            stalls[l]++;
            s_ex[l] = -1;
         end else if (o_fh[l]) begin
            bids[l]++;
            s_ex[l] = s_id[l];
            s_id[l] = -1;
         end else begin
            s_ex[l] = s_id[l];
            if (s_fi[l] < plen) begin
               s_id[l] = s_fi[l];
               s_fi[l]++;
            end else s_id[l] = -1;
         end
      end
   endtask

   task automatic run_prog();
      for (int l = 0; l < 2; l++) begin
         s_id[l] = -1; s_ex[l] = -1; s_mem[l] = -1; s_wb[l] = -1;
         s_fi[l] = 0; stalls[l] = 0; bids[l] = 0;
      end
      while (lane_busy(0) || lane_busy(1)) step();
      step();
   endtask

   task automatic run_case(input string req, input int st_byp, input int st_lock);
      run_prog();
      chk(req, "stall cycles, bypass lane", stalls[0], st_byp);
      chk(req, "stall cycles, interlock lane", stalls[1], st_lock);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         checks++;
         fails++;
         $display("FAIL R1..R10 watchdog: actual %0d cycles expected under 20000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      plen = 0;
      for (int l = 0; l < 2; l++) begin
         s_id[l] = -1; s_ex[l] = -1; s_mem[l] = -1; s_wb[l] = -1; s_fi[l] = 0;
         drive(l);
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      for (int l = 0; l < 2; l++) begin
         chk("R2", "reset fwd_a", int'(o_fa[l]), 0);
         chk("R2", "reset fwd_b", int'(o_fb[l]), 0);
         chk("R2", "reset fwd_sd", int'(o_sd[l]), 0);
      end
      rst_n = 1'b1;

      // R5 R4: ALU feeds ALU
      clr(); i_alu(3, 1, 2); i_alu(5, 3, 4); run_case("R5 R4", 0, 2);
      // R6: load feeds ALU operand B
      clr(); i_ld(2, 1); i_alu(4, 3, 2); run_case("R6 R4", 1, 2);
      // R6: load feeds store address
      clr(); i_ld(2, 1); i_st(2, 3); run_case("R6 R4", 1, 2);
      // R7: load feeds store data only
      clr(); i_ld(2, 1); i_st(3, 2); run_case("R7 R4", 0, 2);
      // R5: ALU feeds store data
      clr(); i_alu(3, 1, 2); i_st(8, 3); run_case("R5 R4", 0, 2);
      // R5: ALU feeds load address
      clr(); i_alu(6, 1, 2); i_ld(7, 6); run_case("R5 R4", 0, 2);
      // R6: load feeds branch
      clr(); i_ld(4, 1); i_br(4, 5); run_case("R6 R4", 1, 2);
      // R5 R4: producer two ahead
      clr(); i_alu(3, 1, 2); i_alu(10, 11, 12); i_alu(5, 4, 3); run_case("R5 R4", 0, 1);
      // R3: producer three ahead
      clr(); i_alu(3, 1, 2); i_nop(); i_nop(); i_alu(5, 3, 4); run_case("R3", 0, 0);
      // R1: zero register never matches
      clr(); i_alu(0, 1, 2); i_alu(5, 0, 0); run_case("R1", 0, 0);
      // R1: unused source ignored
      clr(); i_alu(3, 1, 2); add(0, 5, 3, 3, 0, 0, 1); run_case("R1", 0, 0);
      // R1: writer with write enable low
      clr(); add(0, 3, 1, 2, 1, 1, 0); i_alu(5, 3, 3); run_case("R1", 0, 0);
      // R9: two ALU writers, youngest wins
      clr(); i_alu(5, 1, 2); i_alu(5, 3, 4); i_alu(6, 5, 7); run_case("R9 R4", 0, 2);
      // R9: ALU writer shadows older load
      clr(); i_ld(5, 1); i_alu(5, 2, 3); i_alu(6, 7, 5); run_case("R9 R4", 0, 2);
      // R10: shared port bubble with no dependency
      clr(); i_ld(1, 2); i_alu(3, 4, 5); i_alu(6, 7, 8); run_case("R10", 0, 0);
      chk("R10", "decode bubbles, split lane", bids[0], 0);
      chk("R10", "decode bubbles, shared lane", bids[1], 1);
      // mixed stream
      clr();
      i_ld(2, 1); i_alu(3, 2, 2); i_st(3, 2); i_ld(4, 3); i_st(5, 4);
      i_alu(4, 4, 2); i_br(4, 3); i_alu(7, 4, 3); i_ld(8, 7); i_alu(9, 8, 7);
      run_prog();

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule